// File: doc/BRIEF.md
# Lockable Clock Configuration Register Block

This block is a small register file that holds the clock and power settings of a chip. Software writes it over a byte-wide bus made of an address, a write-data byte and a one-cycle write strobe. Reads are combinational on the same address. The stored settings drive the clock-source selects, the main-clock and PLL controls, the stop-mode request and the watchdog count-source select. The multiplexers, oscillators and PLL that act on these settings are outside the block.

A mode register holds two one-way lock bits. A clock lock freezes chosen bits in the clock-control registers and every bit of both PLL registers. A watchdog lock moves the watchdog onto the on-chip oscillator and blocks stop-mode entry. It also keeps the watchdog counting through wait and hold. Only reset clears either lock. The mode register can be written only while a separate write-enable bit in the protect register is set.

Top module: `clkcfg_guard`

## Requirements
- R1: After reset every register reads 0x00. The mode register (address 0x13) only ever holds bit 1 (clock lock) and bit 2 (watchdog lock). Every other bit of it reads 0, whatever was written.
- R2: A write to the mode register changes it only while bit 0 (write enable) of the protect register at address 0x0A is 1. Otherwise the write is ignored. The protect register stores bit 0 only, and its other bits read 0.
- R3: Once a lock bit in the mode register is 1, no write returns it to 0. Only reset clears it.
- R4: The clock-control registers sit at 0x06 (CTL0), 0x07 (CTL1) and 0x0C (CTL2). The PLL registers sit at 0x1C and 0x1D. While the clock lock is 1, writes leave these bits unchanged: CTL0 bits 2, 5 and 7, CTL1 bits 0 and 7, CTL2 bit 0, and every PLL bit. In the same write, the other bits of these registers take the written value.
- R5: The CPU clock stops when `waitReq` is high, with `cpuClkStop = 1`. While the clock lock is 1, `cpuClkStop` stays 0 even when `waitReq` is high.
- R6: `wdtSrcOsc` is 0 (bus clock) while the watchdog lock is 0. While the lock is 1, `wdtSrcOsc` becomes 1 on the first clock edge at which `oscReady` is high. Once set, it stays 1 until reset.
- R7: While the watchdog lock is 1, writes leave CTL1 bit 0 (stop-mode request) unchanged, and `wdtHalt` stays 0 even when `waitReq` or `holdReq` is high. With the lock at 0, `wdtHalt = waitReq | holdReq`.
- R8: Every register reads back its stored value at its own address. An address that maps to no register reads 0x00.
- R9: The field outputs follow the stored bits:
  - `cpuSrcSel` is {CTL1[7], CTL0[7]}.
  - `mainClkStop` is CTL0[5].
  - `oscStopDetEn` is CTL2[0].
  - `stopModeReq` is CTL1[0].
  - `periphClkStop` is `cpuClkStop & CTL0[2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register address for reads and writes |
| busWrData | input | 8 | Write data |
| busWrEn | input | 1 | Write strobe, one write per cycle it is high |
| busRdData | output | 8 | Read data for `busAddr` |
| waitReq | input | 1 | Wait-state request from the core |
| holdReq | input | 1 | Hold-state request |
| oscReady | input | 1 | On-chip oscillator has started |
| cpuClkStop | output | 1 | Gate the CPU clock |
| periphClkStop | output | 1 | Gate the peripheral clock |
| wdtHalt | output | 1 | Stop the watchdog count |
| wdtSrcOsc | output | 1 | Watchdog count source: 1 selects the oscillator, 0 selects the bus clock |
| stopModeReq | output | 1 | Stop-mode request |
| cpuSrcSel | output | 2 | CPU clock source selects |
| mainClkStop | output | 1 | Main clock stop |
| oscStopDetEn | output | 1 | Oscillation-stop detect enable |
| pllCfg0 | output | 8 | PLL control byte 0 |
| pllCfg1 | output | 8 | PLL control byte 1 |

## Verification
Some behaviours are checked by the assertions on every cycle:
- the reserved mode bits stay zero, and the two locks never fall;
- a mode write without the write-enable bit changes nothing;
- a write under the clock lock leaves the PLL bytes unchanged, and one under the watchdog lock leaves the stop request unchanged;
- the CPU clock is never gated while the clock lock is set;
- the watchdog source follows the lock and oscillator-ready rule.

Only the bench's scenarios can show the bit-level merge: locked bits keep their old value while their unlocked neighbours take new data in the same write. The scenarios also show that readback at every address is exact, and that the switch to the oscillator waits for `oscReady` and lands one edge later.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 8;
  localparam int NUM_CFG = 5;

  localparam logic [ADDR_W-1:0] ADDR_MODE = 8'h13;
  localparam logic [ADDR_W-1:0] ADDR_PROT = 8'h0A;

  localparam int MODE_CLK_LOCK = 1;
  localparam int MODE_WDT_LOCK = 2;
  localparam int PROT_WEN      = 0;
  localparam int CTL0_PSTOP    = 2;
  localparam int CTL0_MSTOP    = 5;
  localparam int CTL0_SRC      = 7;
  localparam int CTL1_STOP     = 0;
  localparam int CTL1_SRC      = 7;
  localparam int CTL2_OSD      = 0;

  localparam logic [DATA_W-1:0] MODE_KEEP =
    DATA_W'((1 << MODE_CLK_LOCK) | (1 << MODE_WDT_LOCK));

  // Index into the configuration array
  localparam int IDX_CTL0 = 0;
  localparam int IDX_CTL1 = 1;
  localparam int IDX_CTL2 = 2;
  localparam int IDX_PLL0 = 3;
  localparam int IDX_PLL1 = 4;

  typedef struct packed {
    logic               mode;
    logic               prot;
    logic [NUM_CFG-1:0] cfg;
  } wrStrobe_t;

  function automatic logic [ADDR_W-1:0] cfgAddr(input int idx);
    case (idx)
      IDX_CTL0: cfgAddr = 8'h06;
      IDX_CTL1: cfgAddr = 8'h07;
      IDX_CTL2: cfgAddr = 8'h0C;
      IDX_PLL0: cfgAddr = 8'h1C;
      default:  cfgAddr = 8'h1D;
    endcase
  endfunction

  // Bits frozen by the clock lock, per register
  function automatic logic [DATA_W-1:0] clkLockMask(input int idx);
    case (idx)
      IDX_CTL0: clkLockMask = DATA_W'((1 << CTL0_PSTOP) | (1 << CTL0_MSTOP) | (1 << CTL0_SRC));
      IDX_CTL1: clkLockMask = DATA_W'((1 << CTL1_STOP) | (1 << CTL1_SRC));
      IDX_CTL2: clkLockMask = DATA_W'(1 << CTL2_OSD);
      default:  clkLockMask = '1;
    endcase
  endfunction

  // Bits frozen by the watchdog lock, per register
  function automatic logic [DATA_W-1:0] wdtLockMask(input int idx);
    wdtLockMask = (idx == IDX_CTL1) ? DATA_W'(1 << CTL1_STOP) : '0;
  endfunction

  function automatic logic [DATA_W-1:0] mergeWr(input logic [DATA_W-1:0] oldVal,
                                                input logic [DATA_W-1:0] newVal,
                                                input logic [DATA_W-1:0] frozen);
    mergeWr = (oldVal & frozen) | (newVal & ~frozen);
  endfunction
endpackage

// File: rtl/clkcfg_ctrl.sv
module clkcfg_ctrl
  import clkcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              protEn,
  input  logic              wdtLock,
  input  logic              oscReady,
  output wrStrobe_t         wrStb,
  output logic              wdtSrcOsc
);
  logic srcOscQ;

  always_comb begin
    wrStb      = '0;
    wrStb.mode = busWrEn && (busAddr == ADDR_MODE) && protEn;
    wrStb.prot = busWrEn && (busAddr == ADDR_PROT);
    for (int i = 0; i < NUM_CFG; i++) begin
      wrStb.cfg[i] = busWrEn && (busAddr == cfgAddr(i));
    end
  end

  // Switch to the oscillator only once it reports ready
  always_ff @(posedge clk) begin
    if (!rstN)                     srcOscQ <= 1'b0;
    else if (wdtLock && oscReady)  srcOscQ <= 1'b1;
  end

  assign wdtSrcOsc = srcOscQ;
endmodule

// File: rtl/clkcfg_datapath.sv
module clkcfg_datapath
  import clkcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         wrStb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic [DATA_W-1:0] modeQ,
  output logic              protEn,
  output logic [DATA_W-1:0] cfgQ [NUM_CFG]
);
  logic clkLock;
  logic wdtLock;

  assign clkLock = modeQ[MODE_CLK_LOCK];
  assign wdtLock = modeQ[MODE_WDT_LOCK];

  // Lock bits only ever rise; reserved bits are never stored
  always_ff @(posedge clk) begin
    if (!rstN)          modeQ <= '0;
    else if (wrStb.mode) modeQ <= modeQ | (busWrData & MODE_KEEP);
  end

  always_ff @(posedge clk) begin
    if (!rstN)           protEn <= 1'b0;
    else if (wrStb.prot) protEn <= busWrData[PROT_WEN];
  end

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    logic [DATA_W-1:0] frozen;
    assign frozen = (clkLock ? clkLockMask(g) : '0) | (wdtLock ? wdtLockMask(g) : '0);
    always_ff @(posedge clk) begin
      if (!rstN)             cfgQ[g] <= '0;
      else if (wrStb.cfg[g]) cfgQ[g] <= mergeWr(cfgQ[g], busWrData, frozen);
    end
  end

  always_comb begin
    busRdData = '0;
    if (busAddr == ADDR_MODE) busRdData = modeQ;
    if (busAddr == ADDR_PROT) busRdData = DATA_W'(protEn) << PROT_WEN;
    for (int i = 0; i < NUM_CFG; i++) begin
      if (busAddr == cfgAddr(i)) busRdData = cfgQ[i];
    end
  end
endmodule

// File: rtl/clkcfg_guard.sv
module clkcfg_guard
  import clkcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWrEn,
  output logic [DATA_W-1:0] busRdData,
  input  logic              waitReq,
  input  logic              holdReq,
  input  logic              oscReady,
  output logic              cpuClkStop,
  output logic              periphClkStop,
  output logic              wdtHalt,
  output logic              wdtSrcOsc,
  output logic              stopModeReq,
  output logic [1:0]        cpuSrcSel,
  output logic              mainClkStop,
  output logic              oscStopDetEn,
  output logic [DATA_W-1:0] pllCfg0,
  output logic [DATA_W-1:0] pllCfg1
);
  wrStrobe_t         wrStb;
  logic [DATA_W-1:0] modeQ;
  logic              protEn;
  logic [DATA_W-1:0] cfgQ [NUM_CFG];
  logic              clkLock;
  logic              wdtLock;

  assign clkLock = modeQ[MODE_CLK_LOCK];
  assign wdtLock = modeQ[MODE_WDT_LOCK];

  clkcfg_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .protEn    (protEn),
    .wdtLock   (wdtLock),
    .oscReady  (oscReady),
    .wrStb     (wrStb),
    .wdtSrcOsc (wdtSrcOsc)
  );

  clkcfg_datapath i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wrStb     (wrStb),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .modeQ     (modeQ),
    .protEn    (protEn),
    .cfgQ      (cfgQ)
  );

  assign cpuClkStop    = waitReq && !clkLock;
  assign periphClkStop = cpuClkStop && cfgQ[IDX_CTL0][CTL0_PSTOP];
  assign wdtHalt       = (waitReq || holdReq) && !wdtLock;
  assign stopModeReq   = cfgQ[IDX_CTL1][CTL1_STOP];
  assign cpuSrcSel     = {cfgQ[IDX_CTL1][CTL1_SRC], cfgQ[IDX_CTL0][CTL0_SRC]};
  assign mainClkStop   = cfgQ[IDX_CTL0][CTL0_MSTOP];
  assign oscStopDetEn  = cfgQ[IDX_CTL2][CTL2_OSD];
  assign pllCfg0       = cfgQ[IDX_PLL0];
  assign pllCfg1       = cfgQ[IDX_PLL1];
endmodule

// File: rtl/clkcfg_guard_chk.sv
module clkcfg_guard_chk
  import clkcfg_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              oscReady,
  input logic              cpuClkStop,
  input logic              wdtSrcOsc,
  input logic              stopModeReq,
  input logic [DATA_W-1:0] pllCfg0,
  input logic [DATA_W-1:0] pllCfg1,
  input logic [DATA_W-1:0] modeQ,
  input logic              protEn
);
  logic clkLock;
  logic wdtLock;
  assign clkLock = modeQ[MODE_CLK_LOCK];
  assign wdtLock = modeQ[MODE_WDT_LOCK];

  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ & ~MODE_KEEP) == '0);

  p_mode_gated_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_MODE && !protEn) |=> $stable(modeQ));

  p_clk_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    clkLock |=> clkLock);

  p_wdt_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    wdtLock |=> wdtLock);

  p_pll_frozen_r4: assert property (@(posedge clk) disable iff (!rstN)
    (clkLock && busWrEn) |=> ($stable(pllCfg0) && $stable(pllCfg1)));

  p_cpu_runs_r5: assert property (@(posedge clk) disable iff (!rstN)
    clkLock |-> !cpuClkStop);

  p_src_needs_lock_r6: assert property (@(posedge clk) disable iff (!rstN)
    !wdtLock |-> !wdtSrcOsc);

  p_src_switch_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wdtLock && oscReady) |=> wdtSrcOsc);

  p_stop_blocked_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wdtLock && busWrEn) |=> $stable(stopModeReq));
endmodule

bind clkcfg_guard clkcfg_guard_chk i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busAddr     (busAddr),
  .busWrEn     (busWrEn),
  .oscReady    (oscReady),
  .cpuClkStop  (cpuClkStop),
  .wdtSrcOsc   (wdtSrcOsc),
  .stopModeReq (stopModeReq),
  .pllCfg0     (pllCfg0),
  .pllCfg1     (pllCfg1),
  .modeQ       (modeQ),
  .protEn      (protEn)
);

// File: tb/test_clkcfg_guard.sv
module test_clkcfg_guard;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_MODE = 8'h13, A_PROT = 8'h0A, A_CTL0 = 8'h06,
                         A_CTL1 = 8'h07, A_CTL2 = 8'h0C, A_PLL0 = 8'h1C,
                         A_PLL1 = 8'h1D;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busRdData;
  logic       waitReq = 1'b0, holdReq = 1'b0, oscReady = 1'b0;
  logic       cpuClkStop, periphClkStop, wdtHalt, wdtSrcOsc, stopModeReq;
  logic [1:0] cpuSrcSel;
  logic       mainClkStop, oscStopDetEn;
  logic [7:0] pllCfg0, pllCfg1;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkcfg_guard i_clkcfg_guard (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .busRdData(busRdData), .waitReq(waitReq),
    .holdReq(holdReq), .oscReady(oscReady), .cpuClkStop(cpuClkStop),
    .periphClkStop(periphClkStop), .wdtHalt(wdtHalt), .wdtSrcOsc(wdtSrcOsc),
    .stopModeReq(stopModeReq), .cpuSrcSel(cpuSrcSel), .mainClkStop(mainClkStop),
    .oscStopDetEn(oscStopDetEn), .pllCfg0(pllCfg0), .pllCfg1(pllCfg1)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; busWrEn = 1'b0; waitReq = 1'b0; holdReq = 1'b0; oscReady = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic readCheck(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    busAddr = a;
    #1;
    check(req, 16'(busRdData), 16'(exp));
  endtask

  // R1, R8: reset values and unmapped address
  task automatic tResetState();
    doReset();
    readCheck("R1 mode reset", A_MODE, 8'h00);
    readCheck("R1 prot reset", A_PROT, 8'h00);
    readCheck("R1 ctl0 reset", A_CTL0, 8'h00);
    readCheck("R1 ctl1 reset", A_CTL1, 8'h00);
    readCheck("R1 ctl2 reset", A_CTL2, 8'h00);
    readCheck("R1 pll0 reset", A_PLL0, 8'h00);
    readCheck("R1 pll1 reset", A_PLL1, 8'h00);
    check("R6 src reset", 16'(wdtSrcOsc), 16'h0);
    busWrite(8'h55, 8'hFF);
    readCheck("R8 unmapped", 8'h55, 8'h00);
  endtask

  // R2: mode writes gated by protect bit
  task automatic tModeGate();
    doReset();
    busWrite(A_MODE, 8'h06);
    readCheck("R2 mode write without enable", A_MODE, 8'h00);
    busWrite(A_PROT, 8'hFF);
    readCheck("R2 prot stores bit0 only", A_PROT, 8'h01);
    busWrite(A_PROT, 8'h00);
    busWrite(A_MODE, 8'h02);
    readCheck("R2 mode after enable cleared", A_MODE, 8'h00);
  endtask

  // R8, R9, R5, R7: unlocked writes and field outputs
  task automatic tUnlocked();
    doReset();
    busWrite(A_CTL0, 8'hA4);
    busWrite(A_CTL1, 8'h80);
    busWrite(A_CTL2, 8'h01);
    busWrite(A_PLL0, 8'h5A);
    busWrite(A_PLL1, 8'h3C);
    readCheck("R8 ctl0", A_CTL0, 8'hA4);
    readCheck("R8 ctl1", A_CTL1, 8'h80);
    readCheck("R8 ctl2", A_CTL2, 8'h01);
    readCheck("R8 pll0", A_PLL0, 8'h5A);
    readCheck("R8 pll1", A_PLL1, 8'h3C);
    check("R9 cpuSrcSel", 16'(cpuSrcSel), 16'h3);
    check("R9 mainClkStop", 16'(mainClkStop), 16'h1);
    check("R9 oscStopDetEn", 16'(oscStopDetEn), 16'h1);
    check("R9 pll outputs", {pllCfg1, pllCfg0}, 16'h3C5A);
    busWrite(A_CTL1, 8'h81);
    check("R9 stopModeReq", 16'(stopModeReq), 16'h1);
    busWrite(A_CTL1, 8'h80);
    @(negedge clk); waitReq = 1'b1; #1;
    check("R5 cpu stops unlocked", 16'(cpuClkStop), 16'h1);
    check("R9 periph stops in wait", 16'(periphClkStop), 16'h1);
    check("R7 wdt halts unlocked", 16'(wdtHalt), 16'h1);
    waitReq = 1'b0; holdReq = 1'b1; #1;
    check("R7 wdt halts on hold unlocked", 16'(wdtHalt), 16'h1);
    holdReq = 1'b0;
  endtask

  // R1, R3, R4, R5: clock lock
  task automatic tClockLock();
    doReset();
    busWrite(A_CTL0, 8'hA4);
    busWrite(A_CTL1, 8'h80);
    busWrite(A_CTL2, 8'h01);
    busWrite(A_PLL0, 8'h5A);
    busWrite(A_PROT, 8'h01);
    busWrite(A_MODE, 8'hFB);
    readCheck("R1 reserved bits dropped", A_MODE, 8'h02);
    busWrite(A_MODE, 8'h00);
    readCheck("R3 clock lock sticky", A_MODE, 8'h02);
    busWrite(A_CTL0, 8'h5B);
    readCheck("R4 ctl0 partial merge", A_CTL0, 8'hFF);
    busWrite(A_CTL0, 8'h00);
    readCheck("R4 ctl0 locked bits kept", A_CTL0, 8'hA4);
    busWrite(A_CTL1, 8'h01);
    readCheck("R4 ctl1 frozen", A_CTL1, 8'h80);
    busWrite(A_CTL2, 8'hF0);
    readCheck("R4 ctl2 merge", A_CTL2, 8'hF1);
    busWrite(A_PLL0, 8'h00);
    readCheck("R4 pll0 frozen", A_PLL0, 8'h5A);
    busWrite(A_PLL1, 8'hFF);
    readCheck("R4 pll1 frozen", A_PLL1, 8'h00);
    @(negedge clk); waitReq = 1'b1; #1;
    check("R5 cpu runs under lock", 16'(cpuClkStop), 16'h0);
    check("R9 periph runs under lock", 16'(periphClkStop), 16'h0);
    waitReq = 1'b0;
    doReset();
    readCheck("R3 reset clears lock", A_MODE, 8'h00);
  endtask

  // R6, R7: watchdog lock
  task automatic tWatchdogLock();
    doReset();
    busWrite(A_PROT, 8'h01);
    busWrite(A_MODE, 8'h04);
    readCheck("R3 wdt lock set", A_MODE, 8'h04);
    busWrite(A_MODE, 8'h00);
    readCheck("R3 wdt lock sticky", A_MODE, 8'h04);
    busWrite(A_CTL1, 8'h01);
    readCheck("R7 stop bit blocked", A_CTL1, 8'h00);
    check("R7 stopModeReq low", 16'(stopModeReq), 16'h0);
    busWrite(A_CTL1, 8'h80);
    readCheck("R7 other ctl1 bit free", A_CTL1, 8'h80);
    @(negedge clk); waitReq = 1'b1; holdReq = 1'b1; #1;
    check("R7 wdt runs in wait/hold", 16'(wdtHalt), 16'h0);
    check("R5 cpu still stops without clock lock", 16'(cpuClkStop), 16'h1);
    waitReq = 1'b0; holdReq = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 no switch before ready", 16'(wdtSrcOsc), 16'h0);
    oscReady = 1'b1; #1;
    check("R6 no switch before edge", 16'(wdtSrcOsc), 16'h0);
    @(negedge clk);
    check("R6 switch after ready", 16'(wdtSrcOsc), 16'h1);
    oscReady = 1'b0;
    @(negedge clk);
    check("R6 source stays on oscillator", 16'(wdtSrcOsc), 16'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    tResetState();
    tModeGate();
    tUnlocked();
    tClockLock();
    tWatchdogLock();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule